// File: doc/BRIEF.md
# Burst DMA Request Scheduler

This block sits between a pixel buffer and a DMA engine. It decides when to ask the DMA engine for the next burst. A request goes out once the buffer holds at least one burst of data and a programmable gap since the last accepted burst has passed. Accepted bursts are counted into blocks. Software can also suppress requests while frame information is being read.

The burst length and the block size do not take effect as soon as they are written. Each is copied into an active (shadow) register at one of two boundaries, chosen by a control input: the end of a block or the end of a frame. Every time this copy happens, the block emits a one-cycle update pulse.

The pacing gap is written as a thermometer code. The number of set bits in the 16-bit field is the gap in cycles. Address generation, the bus protocol and the buffer storage are handled elsewhere.

Top module: `burst_req_sched`

## Requirements
- R1: While and after reset, `req`, `cfg_upd` and `blk_end` are low, `act_len` is 128, and the active block size is 8191 bursts.
- R2: The internal request sets one cycle after a sample in which all of these hold: the request is not already set, the gap has expired, `fill_lvl >= act_len`, and requests are not masked. Once set, the request stays set until a cycle with `req` and `dma_ack` both high, called an accept.
- R3: After an accept, `req` stays low for at least N cycles. N is the number of set bits in `cfg_gap`, with a value of 0 treated as 1. For example, 16'h0007 gives 3 cycles and 16'hFFFF gives 16.
- R4: When `cfg_mask_en` and `info_rd` are both high, `req` is low in that same cycle and no accept occurs. When `cfg_mask_en` is low, `info_rd` has no effect.
- R5: A block ends in two cases: on the accept that brings the accepted-burst count of the current block up to the active block size (a size of 0 is treated as 1), or on a `blk_done` pulse. `blk_end` pulses in the cycle after a block ends. Both a block end and `frame_end` reset the burst count to zero.
- R6: With `cfg_by_blk` high, `cfg_len` and `cfg_blk` are copied into the active registers at every block end. The copied values are visible from the next cycle.
- R7: With `cfg_by_blk` low, the copy happens only on `frame_end`. Block ends leave `act_len` unchanged.
- R8: `cfg_upd` is high in exactly the cycle after each copy. `act_len` changes only in such a cycle.
- R9: After a copy, the comparison of fill level against burst length uses the new `act_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len | input | 12 | Burst length to copy into the active register |
| cfg_blk | input | 13 | Bursts per block to copy into the active register |
| cfg_by_blk | input | 1 | 1: copy at block end, 0: copy at frame end |
| cfg_gap | input | 16 | Thermometer-coded gap after each accept |
| cfg_mask_en | input | 1 | Enables masking of requests during info reads |
| fill_lvl | input | 14 | Buffer fill level |
| dma_ack | input | 1 | DMA acknowledge of the pending request |
| blk_done | input | 1 | Block-done indication from the DMA side |
| frame_end | input | 1 | End-of-frame strobe |
| info_rd | input | 1 | Frame information is being read |
| req | output | 1 | Burst request |
| act_len | output | 12 | Active burst length |
| cfg_upd | output | 1 | One-cycle pulse after the active configuration is copied |
| blk_end | output | 1 | One-cycle pulse after a block ends |

## Verification
Two outputs are due one cycle after the edge that samples their cause: the rising edge of `req`, and `act_len` together with `cfg_upd` and `blk_end`. The masking in R4 works without a clock and pulls `req` low in the same cycle as `info_rd`. The bench advances its reference model at each rising edge, from the same input values the design samples, and changes inputs just after that edge. It compares every output at the falling edge that follows, so both the registered and the same-cycle results are checked in the cycle they are due. The directed checks measure gap lengths and count pulses over windows long enough to hold the expected values.

// File: rtl/burst_req_sched.sv
module burst_req_sched #(
  parameter int LEN_W   = 12,
  parameter int BLK_W   = 13,
  parameter int LVL_W   = 14,
  parameter int GAP_W   = 16,
  parameter int LEN_RST = 128,
  parameter int BLK_RST = 8191
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [BLK_W-1:0] cfg_blk,
  input  logic             cfg_by_blk,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic             cfg_mask_en,
  input  logic [LVL_W-1:0] fill_lvl,
  input  logic             dma_ack,
  input  logic             blk_done,
  input  logic             frame_end,
  input  logic             info_rd,
  output logic             req,
  output logic [LEN_W-1:0] act_len,
  output logic             cfg_upd,
  output logic             blk_end
);

  localparam int PC_W  = $clog2(GAP_W + 1);
  localparam int CMP_W = (LVL_W > LEN_W) ? LVL_W : LEN_W;

  logic             req_q;
  logic [PC_W-1:0]  gap_q;
  logic [PC_W-1:0]  gap_bits;
  logic [PC_W-1:0]  gap_load;
  logic [BLK_W-1:0] cnt_q;
  logic [BLK_W-1:0] blk_q;
  logic             masked, take, last_burst, blk_evt, load, fill_ok;

  always_comb begin
    gap_bits = '0;
    for (int i = 0; i < GAP_W; i++)
      gap_bits = gap_bits + PC_W'(cfg_gap[i]);
  end

  assign gap_load   = (gap_bits == '0) ? '0 : gap_bits - PC_W'(1);
  assign masked     = cfg_mask_en & info_rd;
  assign req        = req_q & ~masked;
  assign take       = req & dma_ack;
  assign last_burst = take && ((BLK_W+1)'(cnt_q) + (BLK_W+1)'(1) >= (BLK_W+1)'(blk_q));
  assign blk_evt    = last_burst | blk_done;
  assign load       = cfg_by_blk ? blk_evt : frame_end;
  assign fill_ok    = CMP_W'(fill_lvl) >= CMP_W'(act_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      gap_q   <= '0;
      cnt_q   <= '0;
      blk_q   <= BLK_W'(BLK_RST);
      act_len <= LEN_W'(LEN_RST);
      cfg_upd <= 1'b0;
      blk_end <= 1'b0;
    end else begin
      if (req_q)
        req_q <= ~take;
      else
        req_q <= (gap_q == '0) & fill_ok & ~masked;

      if (take)
        gap_q <= gap_load;
      else if (gap_q != '0)
        gap_q <= gap_q - PC_W'(1);

      if (blk_evt | frame_end)
        cnt_q <= '0;
      else if (take)
        cnt_q <= cnt_q + BLK_W'(1);

      if (load) begin
        act_len <= cfg_len;
        blk_q   <= cfg_blk;
      end
      cfg_upd <= load;
      blk_end <= blk_evt;
    end
  end

endmodule

module burst_req_sched_chk #(
  parameter int LEN_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             dma_ack,
  input logic             cfg_mask_en,
  input logic             info_rd,
  input logic             cfg_by_blk,
  input logic             frame_end,
  input logic             blk_done,
  input logic             cfg_upd,
  input logic             blk_end,
  input logic [LEN_W-1:0] act_len
);

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !dma_ack) |=> (req || (cfg_mask_en && info_rd)));

  assert_gap_after_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && dma_ack) |=> !req);

  assert_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mask_en && info_rd) |-> !req);

  assert_blk_end_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |-> ($past(req && dma_ack) || $past(blk_done)));

  assert_frame_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_by_blk && !frame_end) |=> !cfg_upd);

  assert_len_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_upd |-> $stable(act_len));

endmodule

bind burst_req_sched burst_req_sched_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/burst_req_sched_tb_top.sv
`timescale 1ns/1ps
module burst_req_sched_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_len = 12'd128;
  logic [12:0] cfg_blk = 13'd8191;
  logic        cfg_by_blk = 1'b0;
  logic [15:0] cfg_gap = 16'h0001;
  logic        cfg_mask_en = 1'b0;
  logic [13:0] fill_lvl = '0;
  logic        dma_ack = 1'b0;
  logic        blk_done = 1'b0;
  logic        frame_end = 1'b0;
  logic        info_rd = 1'b0;
  logic        req, cfg_upd, blk_end;
  logic [11:0] act_len;

  int checks = 0, errors = 0, ack_mode = 0;
  int n_req_hi = 0, n_bend = 0, n_upd = 0, low_run = 0, last_low = 0;
  bit prev_req = 0, done = 0;
  int m_req, m_gap, m_cnt, m_len, m_blk, m_upd, m_bend;

  always #2.5 clk = ~clk;

  burst_req_sched dut_i (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    #1;
    case (ack_mode)
      1: dma_ack <= 1'b1;
      2: dma_ack <= ($urandom % 3) != 0;
      default: dma_ack <= 1'b0;
    endcase
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_req = 0; m_gap = 0; m_cnt = 0; m_len = 128; m_blk = 8191; m_upd = 0; m_bend = 0;
    end else begin
      int pc, nreq, ngap, ncnt;
      bit msk, acc, bend, ld;
      pc = 0;
      for (int i = 0; i < 16; i++) pc += cfg_gap[i];
      if (pc == 0) pc = 1;
      msk  = cfg_mask_en && info_rd;
      acc  = m_req && !msk && dma_ack;
      bend = (acc && (m_cnt + 1 >= m_blk)) || blk_done;
      ld   = cfg_by_blk ? bend : frame_end;
      nreq = m_req ? !acc : (m_gap == 0 && fill_lvl >= m_len && !msk);
      ngap = acc ? pc - 1 : (m_gap > 0 ? m_gap - 1 : 0);
      ncnt = (bend || frame_end) ? 0 : (acc ? m_cnt + 1 : m_cnt);
      if (ld) begin m_len = cfg_len; m_blk = cfg_blk; end
      m_req = nreq; m_gap = ngap; m_cnt = ncnt; m_upd = ld; m_bend = bend;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 req vs model", req, m_req && !(cfg_mask_en && info_rd));
      chk("R6 act_len vs model", act_len, m_len);
      chk("R8 cfg_upd vs model", cfg_upd, m_upd);
      chk("R5 blk_end vs model", blk_end, m_bend);
      if (req) begin
        if (!prev_req && low_run > 0) last_low = low_run;
        low_run = 0;
        n_req_hi++;
      end else low_run++;
      prev_req = req;
      n_bend += blk_end;
      n_upd  += cfg_upd;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R1 req in reset", req, 0);
    rst_n = 1'b1;
    step();
    chk("R1 req after reset", req, 0);
    chk("R1 act_len after reset", act_len, 128);
    chk("R1 cfg_upd after reset", cfg_upd, 0);
    chk("R1 blk_end after reset", blk_end, 0);

    fill_lvl = 100; n_req_hi = 0; step(10);
    chk("R2 no req below burst length", n_req_hi, 0);
    fill_lvl = 128; step(10);
    chk("R2 req held without ack", req, 1);

    ack_mode = 1; cfg_gap = 16'h0007; step(40);
    chk("R3 gap for 16'h0007", last_low, 3);
    cfg_gap = 16'hFFFF; step(80);
    chk("R3 gap for 16'hFFFF", last_low, 16);
    cfg_gap = 16'h0000; step(20);
    chk("R3 gap for zero field", last_low, 1);
    cfg_gap = 16'h0001;

    cfg_mask_en = 1; info_rd = 1; step(3); n_req_hi = 0; step(20);
    chk("R4 masked requests", n_req_hi, 0);
    cfg_mask_en = 0; n_req_hi = 0; step(20);
    chk("R4 info_rd ignored when unmasked", n_req_hi > 0, 1);
    info_rd = 0;

    cfg_by_blk = 0; cfg_len = 64;
    blk_done = 1; step(); blk_done = 0; step(5);
    chk("R7 block end leaves act_len", act_len, 128);
    n_upd = 0;
    frame_end = 1; step(); frame_end = 0; step(2);
    chk("R7 frame end loads act_len", act_len, 64);
    chk("R8 single update pulse", n_upd, 1);

    cfg_by_blk = 1; cfg_blk = 3; cfg_len = 32;
    blk_done = 1; step(); blk_done = 0; step(2);
    chk("R6 block end loads act_len", act_len, 32);
    n_bend = 0; step(60);
    chk("R5 block ends every third burst", (n_bend >= 9 && n_bend <= 11), 1);

    cfg_by_blk = 0; cfg_len = 200; fill_lvl = 150;
    frame_end = 1; step(); frame_end = 0; step(3);
    n_req_hi = 0; step(20);
    chk("R9 new length blocks request", n_req_hi, 0);
    fill_lvl = 200; n_req_hi = 0; step(20);
    chk("R9 new length met", n_req_hi > 0, 1);

    ack_mode = 2;
    for (int k = 0; k < 3000; k++) begin
      fill_lvl    = 14'($urandom % 300);
      frame_end   = ($urandom % 40) == 0;
      blk_done    = ($urandom % 50) == 0;
      info_rd     = ($urandom % 6) == 0;
      if (($urandom % 100) == 0) cfg_mask_en = ~cfg_mask_en;
      if (($urandom % 60) == 0) cfg_by_blk = ~cfg_by_blk;
      if (($urandom % 30) == 0) cfg_len = 12'(1 + $urandom % 255);
      if (($urandom % 30) == 0) cfg_blk = 13'($urandom % 6);
      if (($urandom % 40) == 0) cfg_gap = 16'((1 << ($urandom % 17)) - 1);
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule